// File: doc/BRIEF.md
# Vectored Two-Output Interrupt Controller

This block collects sixty-four synchronous interrupt lines, held as two banks of thirty-two, into two processor request outputs. One output is the normal request and the other is the fast request. Each line has three controls of its own:

- whether it is recognised as a level or as an edge;
- which sense is active;
- which output it drives.

Edge events are held in a latch until software clears them. A software-set register can force any line to pending.

Software reaches the block through a small word-addressed register port. Enables change only through separate set-mask and clear-mask writes.

For the normal output there is a vector port with two parts:

- Reading the vector register returns the number of the highest-priority pending line and opens a service window. The lowest line number has the highest priority.
- While the window is open, that line and every line with a larger number are held off the normal output.
- Any write to the vector-end register closes the window.

When nothing is pending, the vector read returns a software-programmed "nothing pending" value.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, all enables, route, mode, polarity and soft-force bits are 0. `irq_o` and `fiq_o` are low. The "nothing pending" value is 0x000000FF.
- R2: Register map (byte offsets). Banked registers sit at base (bank 0, lines 0..31) and base+4 (bank 1, lines 32..63), and line n uses bit n mod 32.
  - Banked bases: route 0x00, mode 0x08, polarity 0x10, enable readback 0x18, enable-set 0x20, enable-clear 0x28, latch-clear 0x30, soft-force 0x38, raw status 0x40, normal status 0x48, fast status 0x50.
  - Single registers: master 0x58, nothing-pending value 0x5C, vector read 0x60, vector end 0x64, service status 0x68.
  - A read returns its data on `bus_rdata_o` one clock after the read strobe.
- R3: Writing ones to enable-set sets those enables, and writing ones to enable-clear clears them. Zero bits change nothing. The enable readback register shows the current enables.
- R4: For a line with mode bit 0 (level), raw status follows the input XOR its polarity bit, with no latching.
- R5: For a line with mode bit 1 (edge), the latch is set when the polarity-corrected input goes from 0 to 1. Polarity 1 therefore means a falling input.
  - The latch holds after the input returns.
  - Writing a 1 to the line's latch-clear bit clears it.
  - A new edge in the same cycle as a clear wins over the clear.
- R6: A soft-force bit of 1 makes the line pending in raw status, whatever its input is.
- R7: A route bit of 1 sends an enabled pending line to fast status and `fiq_o`. A route bit of 0 sends it to normal status and `irq_o`.
- R8: Master bit 0 gates `irq_o` and master bit 1 gates `fiq_o`. The status registers are not affected by the master bits.
- R9: A vector read returns the smallest-numbered enabled, pending, normal-routed line that the service window lets through. When there is none, it returns the "nothing pending" value.
- R10: A vector read that finds a line opens the service window on that line.
  - The service status register reads bit 31 = 1 with the line number in the low bits while the window is open, and 0 otherwise.
  - While the window is open, that line and all larger-numbered lines are kept off `irq_o` and off later vector reads. Smaller-numbered lines still get through.
  - A write to vector end closes the window. Only one level is held, so a later successful read replaces the window.
- R11: `irq_o` and `fiq_o` are registered. They change on the first clock edge after the pending state that drives them changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 64 | Interrupt lines, synchronous to clk |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default bank width of 32, which gives the full sixty-four lines. This puts bank-1 lines such as 40 within reach. The bench can therefore check the bank-select address bit, and it can check priority across the bank boundary, where a bank-0 line must beat a latched bank-1 edge. The service window is checked with pending lines on both sides of the line in service. This shows that smaller-numbered lines pass and larger-numbered ones are held.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned ADDR_W = 8;

  typedef enum logic [4:0] {
    R_NONE, R_ROUTE, R_MODE, R_POL, R_EN, R_ENSET, R_ENCLR, R_PCLR,
    R_SOFT, R_RAW, R_IRQST, R_FIQST, R_MASTER, R_NOPEND, R_VECRD,
    R_VECWR, R_INSVC
  } reg_e;

  // Group index is addr[6:3]; addr[2] picks the bank or the odd single register.
  function automatic reg_e decode(input logic [ADDR_W-1:0] a);
    reg_e r;
    r = R_NONE;
    if (a[7] == 1'b0 && a[1:0] == 2'b00) begin
      case (a[6:3])
        4'd0:    r = R_ROUTE;
        4'd1:    r = R_MODE;
        4'd2:    r = R_POL;
        4'd3:    r = R_EN;
        4'd4:    r = R_ENSET;
        4'd5:    r = R_ENCLR;
        4'd6:    r = R_PCLR;
        4'd7:    r = R_SOFT;
        4'd8:    r = R_RAW;
        4'd9:    r = R_IRQST;
        4'd10:   r = R_FIQST;
        4'd11:   r = a[2] ? R_NOPEND : R_MASTER;
        4'd12:   r = a[2] ? R_VECWR : R_VECRD;
        4'd13:   r = a[2] ? R_NONE : R_INSVC;
        default: r = R_NONE;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/icu_src_bank.sv
module icu_src_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] soft_i,
  input  logic [W-1:0] pclr_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] corr;
  logic [W-1:0] corr_q;
  logic [W-1:0] hit;
  logic [W-1:0] lat_q;
  logic [W-1:0] lat_d;
  logic         lat_en;

  assign corr = src_i ^ pol_i;
  assign hit  = edge_i & corr & ~corr_q;

  always_comb begin
    lat_en = |(hit | pclr_i | (lat_q & ~edge_i));
    lat_d  = (lat_q & edge_i & ~pclr_i) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q <= '0;
      lat_q  <= '0;
    end else begin
      corr_q <= corr;
      if (lat_en) lat_q <= lat_d;
    end
  end

  assign raw_o = (edge_i & lat_q) | (~edge_i & corr) | soft_i;

  // R5
  edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((lat_q & $past(hit)) == $past(hit)));

  // R5
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pclr_i & ~hit)) |=> ((lat_q & $past(pclr_i & ~hit)) == '0));
endmodule

// File: rtl/icu_prio_pick.sv
module icu_prio_pick #(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int unsigned BANK_W     = 32,
  parameter logic [31:0] NOPEND_RST = 32'h0000_00FF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2*BANK_W-1:0]        src_i,
  input  logic                       bus_wr_i,
  input  logic                       bus_rd_i,
  input  logic [icu_pkg::ADDR_W-1:0] bus_addr_i,
  input  logic [BANK_W-1:0]          bus_wdata_i,
  output logic [BANK_W-1:0]          bus_rdata_o,
  output logic                       irq_o,
  output logic                       fiq_o
);
  import icu_pkg::*;

  localparam int unsigned NBANK   = 2;
  localparam int unsigned NUM_SRC = NBANK * BANK_W;
  localparam int unsigned IW      = $clog2(NUM_SRC);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  logic [NBANK-1:0][BANK_W-1:0] route_q, route_d;
  logic [NBANK-1:0][BANK_W-1:0] mode_q,  mode_d;
  logic [NBANK-1:0][BANK_W-1:0] pol_q,   pol_d;
  logic [NBANK-1:0][BANK_W-1:0] en_q,    en_d;
  logic [NBANK-1:0][BANK_W-1:0] soft_q,  soft_d;
  logic [NBANK-1:0][BANK_W-1:0] pclr;
  logic [NBANK-1:0][BANK_W-1:0] raw;
  logic [1:0]                   master_q, master_d;
  logic [BANK_W-1:0]            nopend_q, nopend_d;
  logic                         svc_act_q, svc_act_d;
  logic [IW-1:0]                svc_num_q, svc_num_d;
  logic [BANK_W-1:0]            rdata_q, rdata_d;
  logic                         rdata_en;
  logic                         irq_q, irq_d, fiq_q, fiq_d;

  logic [NUM_SRC-1:0] irq_stat, fiq_stat, allow, elig;
  logic               pick_found;
  logic [IW-1:0]      pick_idx;
  reg_e               sel;
  logic               bk;

  assign sel = decode(bus_addr_i);
  assign bk  = bus_addr_i[2];

  // per-bank line conditioning
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    icu_src_bank #(.W(BANK_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_sn),
      .src_i  (src_i[b*BANK_W +: BANK_W]),
      .pol_i  (pol_q[b]),
      .edge_i (mode_q[b]),
      .soft_i (soft_q[b]),
      .pclr_i (pclr[b]),
      .raw_o  (raw[b])
    );
  end

  assign irq_stat = raw & en_q & ~route_q;
  assign fiq_stat = raw & en_q & route_q;

  // service window: only lines numbered below the one in service pass
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_allow
    assign allow[i] = !svc_act_q || (IW'(i) < svc_num_q);
  end
  assign elig = irq_stat & allow;

  icu_prio_pick #(.N(NUM_SRC), .IW(IW)) u_pick (
    .req_i   (elig),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  // next-state logic
  always_comb begin
    route_d   = route_q;
    mode_d    = mode_q;
    pol_d     = pol_q;
    en_d      = en_q;
    soft_d    = soft_q;
    master_d  = master_q;
    nopend_d  = nopend_q;
    svc_act_d = svc_act_q;
    svc_num_d = svc_num_q;
    pclr      = '0;
    if (bus_wr_i) begin
      case (sel)
        R_ROUTE:  route_d[bk] = bus_wdata_i;
        R_MODE:   mode_d[bk]  = bus_wdata_i;
        R_POL:    pol_d[bk]   = bus_wdata_i;
        R_SOFT:   soft_d[bk]  = bus_wdata_i;
        R_ENSET:  en_d[bk]    = en_q[bk] | bus_wdata_i;
        R_ENCLR:  en_d[bk]    = en_q[bk] & ~bus_wdata_i;
        R_PCLR:   pclr[bk]    = bus_wdata_i;
        R_MASTER: master_d    = bus_wdata_i[1:0];
        R_NOPEND: nopend_d    = bus_wdata_i;
        R_VECWR:  svc_act_d   = 1'b0;
        default:  ;
      endcase
    end
    if (bus_rd_i && sel == R_VECRD && pick_found) begin
      svc_act_d = 1'b1;
      svc_num_d = pick_idx;
    end
  end

  // read data
  always_comb begin
    rdata_en = bus_rd_i;
    rdata_d  = '0;
    case (sel)
      R_ROUTE:  rdata_d = route_q[bk];
      R_MODE:   rdata_d = mode_q[bk];
      R_POL:    rdata_d = pol_q[bk];
      R_EN:     rdata_d = en_q[bk];
      R_SOFT:   rdata_d = soft_q[bk];
      R_RAW:    rdata_d = raw[bk];
      R_IRQST:  rdata_d = irq_stat[bk*BANK_W +: BANK_W];
      R_FIQST:  rdata_d = fiq_stat[bk*BANK_W +: BANK_W];
      R_MASTER: rdata_d = {{(BANK_W-2){1'b0}}, master_q};
      R_NOPEND: rdata_d = nopend_q;
      R_VECRD:  rdata_d = pick_found ? {{(BANK_W-IW){1'b0}}, pick_idx} : nopend_q;
      R_INSVC:  rdata_d = svc_act_q ? {1'b1, {(BANK_W-1-IW){1'b0}}, svc_num_q} : '0;
      default:  rdata_d = '0;
    endcase
  end

  assign irq_d = master_q[0] & (|elig);
  assign fiq_d = master_q[1] & (|fiq_stat);

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      route_q   <= '0;
      mode_q    <= '0;
      pol_q     <= '0;
      en_q      <= '0;
      soft_q    <= '0;
      master_q  <= '0;
      nopend_q  <= NOPEND_RST[BANK_W-1:0];
      svc_act_q <= 1'b0;
      svc_num_q <= '0;
      rdata_q   <= '0;
      irq_q     <= 1'b0;
      fiq_q     <= 1'b0;
    end else begin
      route_q   <= route_d;
      mode_q    <= mode_d;
      pol_q     <= pol_d;
      en_q      <= en_d;
      soft_q    <= soft_d;
      master_q  <= master_d;
      nopend_q  <= nopend_d;
      svc_act_q <= svc_act_d;
      svc_num_q <= svc_num_d;
      if (rdata_en) rdata_q <= rdata_d;
      irq_q     <= irq_d;
      fiq_q     <= fiq_d;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;
  assign fiq_o       = fiq_q;

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !master_q[0] |=> !irq_o);

  // R8
  fiq_gate_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !master_q[1] |=> !fiq_o);

  // R10
  vec_end_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_wr_i && sel == R_VECWR) |=> !svc_act_q);

  // R10
  vec_mark_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_rd_i && sel == R_VECRD && pick_found) |=>
      (svc_act_q && bus_rdata_o == {{(BANK_W-IW){1'b0}}, svc_num_q}));

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_wr_i && sel == R_ENSET) |=>
      ((en_q[$past(bk)] & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_wr_i && sel == R_ENCLR) |=>
      ((en_q[$past(bk)] & $past(bus_wdata_i)) == '0));
endmodule

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
  localparam logic [7:0] A_ROUTE = 8'h00, A_MODE = 8'h08, A_POL = 8'h10,
    A_EN = 8'h18, A_ENSET = 8'h20, A_ENCLR = 8'h28, A_PCLR = 8'h30,
    A_SOFT = 8'h38, A_RAW = 8'h40, A_IRQST = 8'h48, A_FIQST = 8'h50,
    A_MASTER = 8'h58, A_NOPEND = 8'h5C, A_VECRD = 8'h60, A_VECWR = 8'h64,
    A_INSVC = 8'h68;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, fiq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  logic  mon_pend = 1'b0;

  always #2.5 clk = ~clk;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(bus_wr),
    .bus_rd_i(bus_rd), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq), .fiq_o(fiq)
  );

  // monitor: compare read data against the scoreboard
  always @(posedge clk) mon_pend <= bus_rd;
  always @(negedge clk) begin
    if (mon_pend) begin
      item_t it;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
      end else begin
        it = sb.pop_front();
        if (bus_rdata !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pin(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, e);
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    pin(irq, 1'b0, "R1 irq low after reset");
    pin(fiq, 1'b0, "R1 fiq low after reset");
    rd(A_EN,     32'h0, "R1 enable bank0 zero");
    rd(A_EN + 4, 32'h0, "R1 enable bank1 zero");
    rd(A_VECRD,  32'hFF, "R1 nothing-pending default");

    // R2 R3 enables through set/clear masks, bank select
    wr(A_MASTER, 32'h3);
    wr(A_ENSET,     32'h0000_0020);
    wr(A_ENSET + 4, 32'h0000_0100);
    rd(A_EN,     32'h20,  "R3 enable set bank0");
    rd(A_EN + 4, 32'h100, "R2 enable set bank1 line 40");
    wr(A_ENCLR, 32'h0);
    rd(A_EN, 32'h20, "R3 zero clear bits no effect");
    wr(A_ENCLR + 4, 32'h100);
    rd(A_EN + 4, 32'h0, "R3 enable clear");
    wr(A_ENSET + 4, 32'h100);

    // R11 registered output timing, R4 level
    @(negedge clk);
    src[5] = 1'b1;
    pin(irq, 1'b0, "R11 irq not yet asserted");
    @(negedge clk);
    pin(irq, 1'b1, "R11 irq one edge after level");
    rd(A_RAW,   32'h20, "R4 level raw");
    rd(A_IRQST, 32'h20, "R7 normal status");
    src[5] = 1'b0;
    idle(2);
    pin(irq, 1'b0, "R4 level not latched pin");
    rd(A_RAW, 32'h0, "R4 level not latched raw");
    wr(A_POL, 32'h20);
    rd(A_RAW, 32'h20, "R4 inverted level active low");
    wr(A_POL, 32'h0);

    // R5 edge on line 40 (bank1 bit 8)
    wr(A_MODE + 4, 32'h100);
    src[40] = 1'b1; idle(1); src[40] = 1'b0; idle(2);
    rd(A_RAW + 4, 32'h100, "R5 rising edge latched");
    pin(irq, 1'b1, "R5 edge drives irq");
    rd(A_VECRD, 32'd40, "R9 vector returns line 40");
    idle(2);
    pin(irq, 1'b0, "R10 in-service line masked");
    rd(A_INSVC, 32'h8000_0028, "R10 service status");
    wr(A_VECWR, 32'h0);
    idle(2);
    pin(irq, 1'b1, "R10 window closed irq back");
    rd(A_INSVC, 32'h0, "R10 service status closed");
    wr(A_PCLR + 4, 32'h100);
    rd(A_RAW + 4, 32'h0, "R5 latch cleared");
    idle(1);
    pin(irq, 1'b0, "R5 cleared irq low");
    wr(A_POL + 4, 32'h100);
    wr(A_PCLR + 4, 32'h100);
    src[40] = 1'b1; idle(2);
    rd(A_RAW + 4, 32'h0, "R5 rising input ignored with polarity 1");
    src[40] = 1'b0; idle(2);
    rd(A_RAW + 4, 32'h100, "R5 falling edge latched");
    wr(A_PCLR + 4, 32'h100);

    // R6 soft force, R7 routing, R8 master gating
    wr(A_SOFT, 32'h8);
    rd(A_RAW,   32'h8, "R6 soft force raw");
    rd(A_IRQST, 32'h0, "R6 disabled line not in status");
    wr(A_ENSET, 32'h8);
    rd(A_IRQST, 32'h8, "R6 soft line enabled");
    wr(A_ROUTE, 32'h8);
    idle(2);
    rd(A_FIQST, 32'h8, "R7 fast status");
    rd(A_IRQST, 32'h0, "R7 not in normal status");
    pin(fiq, 1'b1, "R7 fiq asserted");
    pin(irq, 1'b0, "R7 irq idle");
    wr(A_MASTER, 32'h1);
    idle(2);
    pin(fiq, 1'b0, "R8 fiq gated by master");
    rd(A_FIQST, 32'h8, "R8 status ungated");
    wr(A_MASTER, 32'h3);
    wr(A_ROUTE, 32'h0);

    // R9 R10 priority and service window
    src[5] = 1'b1;
    src[40] = 1'b1; idle(1); src[40] = 1'b0; idle(2);
    rd(A_VECRD, 32'd3, "R9 lowest line wins");
    idle(2);
    pin(irq, 1'b0, "R10 higher-numbered lines held");
    rd(A_INSVC, 32'h8000_0003, "R10 service status line 3");
    wr(A_VECWR, 32'h0);
    idle(2);
    pin(irq, 1'b1, "R10 end reopens irq");
    wr(A_SOFT, 32'h0);
    rd(A_VECRD, 32'd5, "R9 next line 5");
    idle(2);
    pin(irq, 1'b0, "R10 line 5 window holds 40");
    wr(A_ENSET, 32'h2);
    wr(A_SOFT, 32'h2);
    idle(2);
    pin(irq, 1'b1, "R10 smaller line passes window");
    rd(A_VECRD, 32'd1, "R10 nested read replaces window");
    wr(A_VECWR, 32'h0);
    wr(A_SOFT, 32'h0);
    src[5] = 1'b0;
    rd(A_VECRD, 32'd40, "R9 bank1 line after bank0 drained");
    wr(A_VECWR, 32'h0);
    wr(A_PCLR + 4, 32'h100);
    rd(A_VECRD, 32'hFF, "R9 nothing pending");
    rd(A_INSVC, 32'h0, "R10 empty read opens no window");
    wr(A_NOPEND, 32'h1234);
    rd(A_VECRD, 32'h1234, "R9 programmed nothing-pending");
    idle(2);
    pin(irq, 1'b0, "R9 irq idle at end");

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule